// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces vertical sync, horizontal sync and data-enable strobes from one pixel clock. Every waveform is set by count registers given in pixel clocks, not by porch and sync fields per axis.

Each frame lasts vertical-high plus vertical-low clocks. Vertical sync is a window placed at an offset from frame start. Horizontal sync is a high/low pulse train that starts at frame start. Data enable is a second pulse train that starts after its own programmed delay. The block also reports the pixel column and row of the current active pixel, which a downstream pattern source uses to colour it.

All configuration inputs must stay stable while the block is enabled. They are reprogrammed with the enable low.

A standard frame maps onto the counts as follows:
- vertical high = sync lines × line total
- vertical low = (active + front + back porch lines) × line total
- horizontal pulse count = total lines
- data-enable delay = line total × (vertical sync + vertical back porch) + horizontal sync + horizontal back porch

Top module: `pix_timing_gen`

## Requirements
- R1: While `en` is low, or during reset, `vs_o`, `hs_o`, `de_o`, `x_o` and `y_o` are 0. The first clock edge that samples `en` high starts frame position 0. Outputs are registered: the value for position p appears two edges after that first enabled edge plus p edges (position 0 is visible after the second enabled edge).
- R2: The frame period is `cfg_vs_high + cfg_vs_low` clocks. At its end, the frame position and both pulse trains restart together at position 0.
- R3: `vs_o` is 1 for frame positions p with `cfg_vs_delay <= p < cfg_vs_delay + cfg_vs_high`, and 0 for all other positions. A window that runs past the frame end is cut at the frame end.
- R4: `hs_o` is 1 for `cfg_hs_high` clocks and then 0 for `cfg_hs_low` clocks, starting at position 0. This repeats `cfg_hs_count` times per frame. After the last repetition it stays 0 until the frame restarts.
- R5: `de_o` is 0 before position `cfg_de_delay`. From that position it is 1 for `cfg_de_high` clocks and 0 for `cfg_de_low` clocks, repeated `cfg_de_count` times. After that it stays 0 until the frame restarts.
- R6: While `de_o` is 1, `x_o` gives the clock index inside the current data-enable pulse, starting at 0. While `de_o` is 0, `x_o` is 0.
- R7: `y_o` is 0 at frame start. It rises by 1 in the same cycle that `de_o` falls inside a frame, and otherwise holds its value.
- R8: Configuration written while disabled takes full effect at the next enable. A block disabled in mid-frame restarts from position 0 with the new counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds everything at zero |
| cfg_vs_delay | input | 24 | Vertical sync start offset from frame start |
| cfg_vs_high | input | 24 | Vertical sync high time in clocks |
| cfg_vs_low | input | 24 | Vertical sync low time in clocks |
| cfg_hs_high | input | 16 | Horizontal sync high time |
| cfg_hs_low | input | 16 | Horizontal sync low time |
| cfg_hs_count | input | 16 | Horizontal pulses per frame |
| cfg_de_delay | input | 24 | Data-enable start offset from frame start |
| cfg_de_high | input | 16 | Data-enable high time |
| cfg_de_low | input | 16 | Data-enable low time |
| cfg_de_count | input | 16 | Data-enable pulses per frame |
| vs_o | output | 1 | Vertical sync |
| hs_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable |
| x_o | output | 16 | Column inside the active pulse |
| y_o | output | 16 | Completed active lines in this frame |

## Verification
The bench uses three settings:
- A scaled standard frame, run for more than two frames. Porch-derived counts and the frame restart are checked against the arithmetic model.
- A short frame with a late vertical window and too few horizontal pulses. This separates the window offset from frame start and tests that horizontal sync stays low after its count runs out.
- A frame whose vertical window and last data-enable pulse both run past the frame end. This tests truncation and the row reset at restart.

Runs are also stopped in mid-frame and restarted with a new setting. This shows that no state from the earlier run survives the restart.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  // Default widths of the long (frame-scale) and short (line-scale) counts
  localparam int PTG_LONG_W  = 24;
  localparam int PTG_SHORT_W = 16;

  // Half-open window test on zero-extended operands
  function automatic logic win_hit(input logic [PTG_LONG_W:0] p,
                                   input logic [PTG_LONG_W:0] lo,
                                   input logic [PTG_LONG_W:0] len);
    logic [PTG_LONG_W:0] hi_lim;
    hi_lim  = lo + len;
    win_hit = (p >= lo) && (p < hi_lim);
  endfunction
endpackage

// File: rtl/ptg_frame_ctr.sv
module ptg_frame_ctr #(
  parameter int VW = ptg_pkg::PTG_LONG_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [VW-1:0] vs_delay,
  input  logic [VW-1:0] vs_high,
  input  logic [VW-1:0] vs_low,
  output logic [VW:0] pos,
  output logic        running,
  output logic        frame_end,
  output logic        vs_win
);
  localparam int FW = VW + 1;

  logic [FW-1:0] period;
  logic [FW-1:0] last_pos;

  assign period    = {1'b0, vs_high} + {1'b0, vs_low};
  assign last_pos  = period - 1'b1;
  assign frame_end = running && (pos == last_pos);

  if (VW == ptg_pkg::PTG_LONG_W) begin : g_pkg_win
    assign vs_win = running && ptg_pkg::win_hit(pos, {1'b0, vs_delay}, {1'b0, vs_high});
  end else begin : g_local_win
    logic [FW-1:0] win_end;
    assign win_end = {1'b0, vs_delay} + {1'b0, vs_high};
    assign vs_win  = running && (pos >= {1'b0, vs_delay}) && (pos < win_end);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos     <= '0;
      running <= 1'b0;
    end else begin
      running <= 1'b1;
      if (frame_end)    pos <= '0;
      else if (running) pos <= pos + 1'b1;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && frame_end) |=> (pos == '0)) else $error("frame did not restart"); // R2

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pos == '0 && !running)) else $error("counter moved while disabled"); // R1
endmodule

// File: rtl/ptg_pulse_train.sv
module ptg_pulse_train #(
  parameter int W = ptg_pkg::PTG_SHORT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] hi_len,
  input  logic [W-1:0] lo_len,
  input  logic [W-1:0] count,
  output logic [W:0]   pos,
  output logic [W-1:0] idx,
  output logic         in_train,
  output logic         high
);
  logic [W:0] period;
  logic       wrap;

  assign period   = {1'b0, hi_len} + {1'b0, lo_len};
  assign wrap     = (pos == period - 1'b1);
  assign in_train = (idx < count);
  assign high     = in_train && (pos < {1'b0, hi_len});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos <= '0;
      idx <= '0;
    end else if (step) begin
      if (wrap) begin
        pos <= '0;
        if (in_train) idx <= idx + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx <= count) else $error("pulse index beyond count"); // R4
endmodule

// File: rtl/ptg_coord.sv
module ptg_coord #(
  parameter int W = ptg_pkg::PTG_SHORT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         live,
  input  logic         armed,
  input  logic         de_high,
  input  logic         de_in_train,
  input  logic [W:0]   de_pos,
  input  logic [W-1:0] de_idx,
  input  logic [W-1:0] de_hi_len,
  input  logic [W-1:0] de_count,
  output logic         de_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic         de_nx;
  logic [W-1:0] x_nx;
  logic [W-1:0] y_nx;
  logic         past_high;

  assign past_high = (de_pos >= {1'b0, de_hi_len});
  assign de_nx     = armed && de_high;
  assign x_nx      = de_nx ? de_pos[W-1:0] : '0;

  always_comb begin
    if (!armed)           y_nx = '0;
    else if (de_in_train) y_nx = de_idx + {{(W-1){1'b0}}, past_high};
    else                  y_nx = de_count;
  end

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      de_o <= 1'b0;
      x_o  <= '0;
      y_o  <= '0;
    end else begin
      de_o <= de_nx;
      x_o  <= x_nx;
      y_o  <= y_nx;
    end
  end

  AST_X_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(de_o) |-> (x_o == '0)) else $error("column not cleared"); // R6

  AST_Y_STEP: assert property (@(posedge clk) disable iff (rst)
    ($fell(de_o) && y_o != '0) |-> (y_o == $past(y_o) + 1'b1)) else $error("row did not step"); // R7
endmodule

// File: rtl/pix_timing_gen.sv
module pix_timing_gen #(
  parameter int VW = ptg_pkg::PTG_LONG_W,
  parameter int HW = ptg_pkg::PTG_SHORT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [VW-1:0] cfg_vs_delay,
  input  logic [VW-1:0] cfg_vs_high,
  input  logic [VW-1:0] cfg_vs_low,
  input  logic [HW-1:0] cfg_hs_high,
  input  logic [HW-1:0] cfg_hs_low,
  input  logic [HW-1:0] cfg_hs_count,
  input  logic [VW-1:0] cfg_de_delay,
  input  logic [HW-1:0] cfg_de_high,
  input  logic [HW-1:0] cfg_de_low,
  input  logic [HW-1:0] cfg_de_count,
  output logic          vs_o,
  output logic          hs_o,
  output logic          de_o,
  output logic [HW-1:0] x_o,
  output logic [HW-1:0] y_o
);
  logic [VW:0]   fpos;
  logic          running, frame_end, vs_win, live, restart, de_armed;
  logic [HW:0]   hs_pos, de_pos;
  logic [HW-1:0] hs_idx, de_idx;
  logic          hs_in, hs_high, de_in, de_high;

  assign live     = en && running;
  assign restart  = !en || frame_end;
  assign de_armed = running && (fpos >= {1'b0, cfg_de_delay});

  ptg_frame_ctr #(.VW(VW)) u_frame (
    .clk(clk), .rst(rst), .en(en),
    .vs_delay(cfg_vs_delay), .vs_high(cfg_vs_high), .vs_low(cfg_vs_low),
    .pos(fpos), .running(running), .frame_end(frame_end), .vs_win(vs_win)
  );

  ptg_pulse_train #(.W(HW)) u_hs_train (
    .clk(clk), .rst(rst), .clear(restart), .step(running),
    .hi_len(cfg_hs_high), .lo_len(cfg_hs_low), .count(cfg_hs_count),
    .pos(hs_pos), .idx(hs_idx), .in_train(hs_in), .high(hs_high)
  );

  ptg_pulse_train #(.W(HW)) u_de_train (
    .clk(clk), .rst(rst), .clear(restart), .step(de_armed),
    .hi_len(cfg_de_high), .lo_len(cfg_de_low), .count(cfg_de_count),
    .pos(de_pos), .idx(de_idx), .in_train(de_in), .high(de_high)
  );

  ptg_coord #(.W(HW)) u_coord (
    .clk(clk), .rst(rst), .live(live), .armed(de_armed),
    .de_high(de_high), .de_in_train(de_in), .de_pos(de_pos), .de_idx(de_idx),
    .de_hi_len(cfg_de_high), .de_count(cfg_de_count),
    .de_o(de_o), .x_o(x_o), .y_o(y_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      vs_o <= 1'b0;
      hs_o <= 1'b0;
    end else begin
      vs_o <= vs_win;
      hs_o <= hs_high;
    end
  end

  AST_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!vs_o && !hs_o && !de_o && x_o == '0 && y_o == '0)) else $error("outputs active while disabled"); // R1

  AST_HS_IDLE_TAIL: assert property (@(posedge clk) disable iff (rst)
    (live && !hs_in) |=> !hs_o) else $error("hs pulse after count exhausted"); // R4
endmodule

// File: tb/pix_timing_gen_bench.sv
`timescale 1ns/1ps
module pix_timing_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [23:0] vs_dly = '0, vs_hi = '0, vs_lo = '0, de_dly = '0;
  logic [15:0] hs_hi = '0, hs_lo = '0, hs_cnt = '0, de_hi = '0, de_lo = '0, de_cnt = '0;
  logic vs, hs, de;
  logic [15:0] x, y;

  int checks = 0;
  int fails  = 0;
  bit mon_go = 1'b0;
  bit done   = 1'b0;

  typedef struct {
    logic vs, hs, de;
    logic [15:0] x, y;
    int pos;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  pix_timing_gen u_pix_timing_gen (
    .clk(clk), .rst(rst), .en(en),
    .cfg_vs_delay(vs_dly), .cfg_vs_high(vs_hi), .cfg_vs_low(vs_lo),
    .cfg_hs_high(hs_hi), .cfg_hs_low(hs_lo), .cfg_hs_count(hs_cnt),
    .cfg_de_delay(de_dly), .cfg_de_high(de_hi), .cfg_de_low(de_lo), .cfg_de_count(de_cnt),
    .vs_o(vs), .hs_o(hs), .de_o(de), .x_o(x), .y_o(y)
  );

  // Arithmetic model of one frame position, built from the requirements
  function automatic exp_t model(input longint p);
    exp_t e;
    longint hper, dper, l, q, k, r;
    e.pos = int'(p);
    e.vs  = (p >= vs_dly) && (p < longint'(vs_dly) + vs_hi);          // R3
    hper  = longint'(hs_hi) + hs_lo;
    l     = p / hper;
    e.hs  = (l < hs_cnt) && ((p % hper) < hs_hi);                      // R4
    e.de = 1'b0; e.x = '0; e.y = '0;
    if (p >= de_dly) begin                                            // R5
      dper = longint'(de_hi) + de_lo;
      q = p - de_dly; k = q / dper; r = q % dper;
      e.de = (k < de_cnt) && (r < de_hi);
      e.x  = e.de ? 16'(r) : 16'd0;                                    // R6
      e.y  = (k < de_cnt) ? 16'(k + ((r >= de_hi) ? 1 : 0)) : de_cnt;  // R7
    end
    return e;
  endfunction

  function automatic exp_t zero_item();
    exp_t e;
    e.vs = 0; e.hs = 0; e.de = 0; e.x = '0; e.y = '0; e.pos = -1;
    return e;
  endfunction

  // Driver: pushes the expected stream, then enables the block
  task automatic run_cfg(input int n_pos);
    longint fper;
    fper = longint'(vs_hi) + vs_lo;
    sb_q.push_back(zero_item());
    sb_q.push_back(zero_item());
    for (int i = 0; i < n_pos; i++) sb_q.push_back(model(i % fper));
    @(negedge clk);
    en = 1'b1; mon_go = 1'b1;
    do @(negedge clk); while (sb_q.size() != 0);
    mon_go = 1'b0; en = 1'b0;
    @(negedge clk); #1;
    check_idle("R1 after disable");
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (vs || hs || de || x != 0 || y != 0) begin
      fails++;
      $display("FAIL %s: got vs=%0b hs=%0b de=%0b x=%0d y=%0d, expected all zero",
               tag, vs, hs, de, x, y);
    end
  endtask

  // Monitor: compares each produced cycle with the head of the queue
  always @(negedge clk) begin
    #1;
    if (mon_go && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (e.pos < 0 && (vs || hs || de || x != 0 || y != 0)) begin
        fails++;
        $display("FAIL R1 pre-start: got vs=%0b hs=%0b de=%0b x=%0d y=%0d, expected zeros", vs, hs, de, x, y);
      end else if (vs !== e.vs) begin
        fails++; $display("FAIL R3 pos %0d: vs got %0b expected %0b (R2 if past wrap)", e.pos, vs, e.vs);
      end else if (hs !== e.hs) begin
        fails++; $display("FAIL R4 pos %0d: hs got %0b expected %0b", e.pos, hs, e.hs);
      end else if (de !== e.de) begin
        fails++; $display("FAIL R5 pos %0d: de got %0b expected %0b", e.pos, de, e.de);
      end else if (x !== e.x) begin
        fails++; $display("FAIL R6 pos %0d: x got %0d expected %0d", e.pos, x, e.x);
      end else if (y !== e.y) begin
        fails++; $display("FAIL R7 pos %0d: y got %0d expected %0d", e.pos, y, e.y);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 check_idle("R1 in reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1 check_idle("R1 idle after reset");

    // Setting A: scaled standard frame, two frames plus, covers R2 restart
    vs_dly = 0;  vs_hi = 14; vs_lo = 98;
    hs_hi = 1;   hs_lo = 13; hs_cnt = 8;
    de_dly = 46; de_hi = 8;  de_lo = 6; de_cnt = 4;
    run_cfg(244);

    // Setting B: late vertical window, horizontal train exhausted early
    vs_dly = 5; vs_hi = 7; vs_lo = 30;
    hs_hi = 3;  hs_lo = 2; hs_cnt = 4;
    de_dly = 3; de_hi = 4; de_lo = 1; de_cnt = 3;
    run_cfg(80);

    // Setting C: windows cut by the frame end
    vs_dly = 25; vs_hi = 10; vs_lo = 20;
    hs_hi = 2;   hs_lo = 3;  hs_cnt = 100;
    de_dly = 28; de_hi = 5;  de_lo = 1; de_cnt = 2;
    run_cfg(70);

    // R8: stop A in mid-frame, reprogram while disabled, restart with B
    vs_dly = 0;  vs_hi = 14; vs_lo = 98;
    hs_hi = 1;   hs_lo = 13; hs_cnt = 8;
    de_dly = 46; de_hi = 8;  de_lo = 6; de_cnt = 4;
    run_cfg(50);
    vs_dly = 5; vs_hi = 7; vs_lo = 30;
    hs_hi = 3;  hs_lo = 2; hs_cnt = 4;
    de_dly = 3; de_hi = 4; de_lo = 1; de_cnt = 3;
    repeat (3) @(negedge clk);
    #1 check_idle("R8 held low while reprogramming");
    run_cfg(45);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule